// File: doc/BRIEF.md
# Machine Timer and Software Interrupt Block

This block sits next to a processor core and supplies its two local interrupt sources. A 64-bit time counter advances by one on every clock. A 64-bit compare value is held alongside it. While the counter has reached or passed the compare value, the timer interrupt line is high. A single software interrupt flag drives a second level interrupt line. Software raises the flag by writing to one address and lowers it by writing to another.

Access is through a simple single-word bus inside a 4 KiB window. A request is presented for one cycle with a write flag, a word-aligned byte offset and write data. A response appears exactly one cycle later, carrying read data and an error flag. The 64-bit counter and the 64-bit compare value are each reached as two separate 32-bit halves. Software that needs a consistent 64-bit update must order its half writes itself.

Top module: `tick_alarm_ctrl`

## Requirements
- R1: While reset is high and directly after it, the counter, the compare value and the soft flag are all zero, so `irq_timer` is 1 and `irq_soft` is 0.
- R2: When no write targets the counter, its 64-bit value grows by exactly one per clock, including the carry from the low half into the high half.
- R3: A write to offset 0x100 replaces counter bits 31:0 and a write to 0x104 replaces counter bits 63:32, leaving the other half as it was. The written value is taken instead of the increment in that cycle.
- R4: A write to offset 0x108 replaces compare bits 31:0 and a write to 0x10C replaces compare bits 63:32, leaving the other half unchanged.
- R5: `irq_timer` is 1 exactly when the counter is greater than or equal to the compare value, both taken as unsigned 64-bit numbers.
- R6: A write to offset 0x010 with data bit 0 set raises the soft flag. With data bit 0 clear it has no effect, whatever the other bits hold.
- R7: A write to offset 0x014 with data bit 0 set lowers the soft flag. With bit 0 clear it has no effect, and the other bits never matter.
- R8: A read of offset 0x010 or 0x014 returns the soft flag in bit 0 and zero in bits 31:1.
- R9: Reads of 0x100, 0x104, 0x108 and 0x10C return counter bits 31:0, counter bits 63:32, compare bits 31:0 and compare bits 63:32, as they stood in the request cycle. A write response carries zero data.
- R10: A request to any other offset, including an offset that is not a multiple of four, gets `rsp_err` = 1 with zero data and changes no state. Mapped offsets answer with `rsp_err` = 0.
- R11: `rsp_valid` is 1 in the cycle after each request cycle and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (12) | Byte offset inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Offset not mapped |
| irq_timer | output | 1 | Level timer interrupt |
| irq_soft | output | 1 | Level software interrupt |

## Verification
The assertions assume that a request lasts one cycle and that the bus never carries two accesses in the same cycle. This is why a set and a clear of the soft flag cannot collide. The timer-stays-high property also assumes that the counter is never parked at its all-ones value, where it would wrap to zero. The stimulus writes only small values to the counter's upper half. Random offsets come from the six mapped offsets, a few fixed unmapped ones and fully random 12-bit values.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 2 * WORD_W;

  localparam logic [11:0] OFF_SOFT_SET = 12'h010;
  localparam logic [11:0] OFF_SOFT_CLR = 12'h014;
  localparam logic [11:0] OFF_TIME_LO  = 12'h100;
  localparam logic [11:0] OFF_TIME_HI  = 12'h104;
  localparam logic [11:0] OFF_CMP_LO   = 12'h108;
  localparam logic [11:0] OFF_CMP_HI   = 12'h10C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SOFT_SET,
    SEL_SOFT_CLR,
    SEL_TIME_LO,
    SEL_TIME_HI,
    SEL_CMP_LO,
    SEL_CMP_HI
  } reg_sel_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } half_wr_t;

  // Replace one 32-bit half of a 64-bit value.
  function automatic logic [TIME_W-1:0] merge_half(input logic [TIME_W-1:0] cur,
                                                   input logic [WORD_W-1:0] word,
                                                   input logic upper);
    logic [TIME_W-1:0] res;
    res = cur;
    if (upper) res[TIME_W-1:WORD_W] = word;
    else       res[WORD_W-1:0]      = word;
    return res;
  endfunction

  // Select one half of a 64-bit value.
  function automatic logic [WORD_W-1:0] pick_half(input logic [TIME_W-1:0] v,
                                                  input logic upper);
    return upper ? v[TIME_W-1:WORD_W] : v[WORD_W-1:0];
  endfunction

  // Unsigned "deadline reached" test.
  function automatic logic deadline_reached(input logic [TIME_W-1:0] now,
                                            input logic [TIME_W-1:0] due);
    return now >= due;
  endfunction
endpackage

// File: rtl/tac_decode.sv
module tac_decode
  import tac_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if      (addr == ADDR_W'(OFF_SOFT_SET)) sel = SEL_SOFT_SET;
    else if (addr == ADDR_W'(OFF_SOFT_CLR)) sel = SEL_SOFT_CLR;
    else if (addr == ADDR_W'(OFF_TIME_LO))  sel = SEL_TIME_LO;
    else if (addr == ADDR_W'(OFF_TIME_HI))  sel = SEL_TIME_HI;
    else if (addr == ADDR_W'(OFF_CMP_LO))   sel = SEL_CMP_LO;
    else if (addr == ADDR_W'(OFF_CMP_HI))   sel = SEL_CMP_HI;
    else                                    sel = SEL_NONE;
  end
endmodule

// File: rtl/tac_halfreg.sv
module tac_halfreg
  import tac_pkg::*;
#(
  parameter int unsigned HALF_W = 32,
  parameter bit          COUNT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  half_wr_t          wr,
  input  logic [HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] value
);
  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] q;
  logic [FULL_W-1:0] written;
  logic              any_wr;

  assign any_wr  = wr.lo | wr.hi;
  assign written = merge_half(q, wdata, wr.hi);
  assign value   = q;

  generate
    if (COUNT) begin : g_count
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (any_wr) q <= written;
        else             q <= q + FULL_W'(1);
      end
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (any_wr) q <= written;
      end
    end
  endgenerate
endmodule

// File: rtl/tac_softflag.sv
module tac_softflag (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic lower,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (raise) flag <= 1'b1;
    else if (lower) flag <= 1'b0;
  end
endmodule

// File: rtl/tick_alarm_ctrl.sv
module tick_alarm_ctrl
  import tac_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              irq_timer,
  output logic              irq_soft
);
  reg_sel_e          sel;
  logic              acc_wr;
  logic              acc_rd;
  half_wr_t          time_wr;
  half_wr_t          cmp_wr;
  logic              time_wr_any;
  logic              cmp_wr_any;
  logic              soft_raise;
  logic              soft_lower;
  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] cmp_q;
  logic [WORD_W-1:0] rd_mux;

  tac_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (req_addr),
    .sel  (sel)
  );

  assign acc_wr = req_valid & req_write;
  assign acc_rd = req_valid & ~req_write;

  assign time_wr.lo  = acc_wr & (sel == SEL_TIME_LO);
  assign time_wr.hi  = acc_wr & (sel == SEL_TIME_HI);
  assign cmp_wr.lo   = acc_wr & (sel == SEL_CMP_LO);
  assign cmp_wr.hi   = acc_wr & (sel == SEL_CMP_HI);
  assign time_wr_any = time_wr.lo | time_wr.hi;
  assign cmp_wr_any  = cmp_wr.lo | cmp_wr.hi;
  assign soft_raise  = acc_wr & (sel == SEL_SOFT_SET) & req_wdata[0];
  assign soft_lower  = acc_wr & (sel == SEL_SOFT_CLR) & req_wdata[0];

  tac_halfreg #(.HALF_W(WORD_W), .COUNT(1'b1)) u_time (
    .clk   (clk),
    .rst   (rst),
    .wr    (time_wr),
    .wdata (req_wdata),
    .value (time_q)
  );

  tac_halfreg #(.HALF_W(WORD_W), .COUNT(1'b0)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .wr    (cmp_wr),
    .wdata (req_wdata),
    .value (cmp_q)
  );

  tac_softflag u_soft (
    .clk   (clk),
    .rst   (rst),
    .raise (soft_raise),
    .lower (soft_lower),
    .flag  (irq_soft)
  );

  always_comb begin
    case (sel)
      SEL_SOFT_SET, SEL_SOFT_CLR: rd_mux = {{(WORD_W-1){1'b0}}, irq_soft};
      SEL_TIME_LO: rd_mux = pick_half(time_q, 1'b0);
      SEL_TIME_HI: rd_mux = pick_half(time_q, 1'b1);
      SEL_CMP_LO:  rd_mux = pick_half(cmp_q, 1'b0);
      SEL_CMP_HI:  rd_mux = pick_half(cmp_q, 1'b1);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & (sel == SEL_NONE);
      rsp_rdata <= acc_rd ? rd_mux : '0;
    end
  end

  assign irq_timer = deadline_reached(time_q, cmp_q);
endmodule

// File: rtl/tac_checker.sv
module tac_checker
  import tac_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              irq_timer,
  input logic              irq_soft,
  input logic [63:0]       time_q,
  input logic [63:0]       cmp_q,
  input logic              time_wr_any,
  input logic              cmp_wr_any
);
  logic wr_now;
  logic at_set;
  logic at_clr;
  logic at_tlo;
  logic at_thi;

  assign wr_now = req_valid & req_write;
  assign at_set = req_addr == ADDR_W'(OFF_SOFT_SET);
  assign at_clr = req_addr == ADDR_W'(OFF_SOFT_CLR);
  assign at_tlo = req_addr == ADDR_W'(OFF_TIME_LO);
  assign at_thi = req_addr == ADDR_W'(OFF_TIME_HI);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !time_wr_any |=> time_q == $past(time_q) + 64'd1);

  assert_low_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_now && at_tlo) |=> time_q[31:0] == $past(req_wdata));

  assert_high_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_now && at_thi) |=> time_q[63:32] == $past(req_wdata));

  assert_timer_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_timer && !time_wr_any && !cmp_wr_any && time_q != '1) |=> irq_timer);

  assert_cmp_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !cmp_wr_any |=> $stable(cmp_q));

  assert_soft_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_now && at_set && req_wdata[0]) |=> irq_soft);

  assert_soft_lower_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_now && at_clr && req_wdata[0]) |=> !irq_soft);

  assert_soft_still_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_now && (at_set || at_clr)) |=> $stable(irq_soft));

  assert_err_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> rsp_rdata == 32'd0);

  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind tick_alarm_ctrl tac_checker #(.ADDR_W(ADDR_W)) u_tac_checker (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .irq_timer   (irq_timer),
  .irq_soft    (irq_soft),
  .time_q      (time_q),
  .cmp_q       (cmp_q),
  .time_wr_any (time_wr_any),
  .cmp_wr_any  (cmp_wr_any)
);

// File: tb/tick_alarm_ctrl_tb_top.sv
module tick_alarm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        irq_timer;
  logic        irq_soft;

  int checks = 0;
  int failures = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_alarm_ctrl #(.ADDR_W(12)) dut_i (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .rsp_err (rsp_err),
    .irq_timer (irq_timer), .irq_soft (irq_soft)
  );

  // Reference state built from the requirements
  logic [63:0] m_time, m_cmp;
  logic        m_soft;
  logic        e_valid, e_err;
  logic [31:0] e_rdata;
  string       e_tag;

  function automatic bit is_mapped(input logic [11:0] a);
    return a == 12'h010 || a == 12'h014 || a == 12'h100 ||
           a == 12'h104 || a == 12'h108 || a == 12'h10C;
  endfunction

  function automatic logic [31:0] ref_read(input logic [11:0] a);
    case (a)
      12'h010, 12'h014: return {31'd0, m_soft};
      12'h100: return m_time[31:0];
      12'h104: return m_time[63:32];
      12'h108: return m_cmp[31:0];
      12'h10C: return m_cmp[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    if (a == 12'h010 || a == 12'h014) return "R8";
    if (is_mapped(a)) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_time <= '0; m_cmp <= '0; m_soft <= 1'b0;
      e_valid <= 1'b0; e_err <= 1'b0; e_rdata <= '0; e_tag <= "R1";
    end else begin
      e_valid <= req_valid;
      e_err   <= req_valid && !is_mapped(req_addr);
      e_rdata <= (req_valid && !req_write) ? ref_read(req_addr) : 32'd0;
      e_tag   <= tag_of(req_addr);
      // R3: written half wins over the increment
      if (req_valid && req_write && req_addr == 12'h100)
        m_time <= {m_time[63:32], req_wdata};
      else if (req_valid && req_write && req_addr == 12'h104)
        m_time <= {req_wdata, m_time[31:0]};
      else
        m_time <= m_time + 64'd1;
      // R4
      if (req_valid && req_write && req_addr == 12'h108) m_cmp[31:0]  <= req_wdata;
      if (req_valid && req_write && req_addr == 12'h10C) m_cmp[63:32] <= req_wdata;
      // R6 / R7
      if (req_valid && req_write && req_addr == 12'h010 && req_wdata[0]) m_soft <= 1'b1;
      if (req_valid && req_write && req_addr == 12'h014 && req_wdata[0]) m_soft <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !rst && !done) begin
      chk(irq_timer === (m_time >= m_cmp), "R5 irq_timer", 64'(irq_timer), 64'(m_time >= m_cmp));
      chk(irq_soft === m_soft, "R6/R7 irq_soft", 64'(irq_soft), 64'(m_soft));
      chk(rsp_valid === e_valid, "R11 rsp_valid", 64'(rsp_valid), 64'(e_valid));
      if (e_valid) begin
        chk(rsp_rdata === e_rdata, {e_tag, " rsp_rdata"}, 64'(rsp_rdata), 64'(e_rdata));
        chk(rsp_err === e_err, "R10 rsp_err", 64'(rsp_err), 64'(e_err));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    finish_run();
  end

  task automatic op(input logic w, input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset values visible at the ports
    chk(irq_timer === 1'b1, "R1 irq_timer in reset", 64'(irq_timer), 64'd1);
    chk(irq_soft === 1'b0, "R1 irq_soft in reset", 64'(irq_soft), 64'd0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    chk_on = 1'b1;
    // R1/R9: first reads after reset
    op(1'b0, 12'h100, 0); op(1'b0, 12'h104, 0); op(1'b0, 12'h010, 0);
    op(1'b0, 12'h108, 0);
    // R4/R5: compare pushed into the future drops the timer line
    op(1'b1, 12'h10C, 32'd1); op(1'b0, 12'h108, 0); op(1'b0, 12'h10C, 0);
    // R2/R3: low half near wrap, carry into high half
    op(1'b1, 12'h100, 32'hFFFF_FFF0); idle(20); op(1'b0, 12'h104, 0);
    op(1'b0, 12'h100, 0);
    // R5: crossing an exact deadline
    op(1'b1, 12'h104, 32'd0); op(1'b1, 12'h108, 32'd2);
    op(1'b1, 12'h100, 32'hFFFF_FFF8); idle(15);
    // R3: high-half write keeps low half
    op(1'b1, 12'h104, 32'd3); op(1'b0, 12'h100, 0); op(1'b0, 12'h104, 0);
    // R6/R7/R8: soft flag corners
    op(1'b1, 12'h010, 32'hFFFF_FFFE); op(1'b0, 12'h010, 0);
    op(1'b1, 12'h010, 32'h0000_0001); op(1'b0, 12'h014, 0);
    op(1'b1, 12'h014, 32'hFFFF_FFFE); op(1'b0, 12'h010, 0);
    op(1'b1, 12'h014, 32'h0000_0001); op(1'b0, 12'h014, 0);
    // R10: unmapped and misaligned offsets change nothing
    op(1'b1, 12'h018, 32'd1); op(1'b0, 12'h0FC, 0); op(1'b1, 12'h102, 32'hDEAD);
    op(1'b0, 12'h102, 0); op(1'b1, 12'hFFC, 32'd1); op(1'b0, 12'h100, 0);
    // R11: back-to-back requests then random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      int k;
      k = int'($urandom_range(0, 9));
      case (k)
        0: a = 12'h010; 1: a = 12'h014; 2: a = 12'h100; 3: a = 12'h104;
        4: a = 12'h108; 5: a = 12'h10C; 6: a = 12'h018; 7: a = 12'h10E;
        default: a = 12'($urandom());
      endcase
      if (a == 12'h104 || a == 12'h10C) d = 32'($urandom_range(0, 2));
      else d = $urandom();
      if ($urandom_range(0, 3) != 0) op(1'($urandom()), a, d);
      else idle(1);
    end
    idle(3);
    finish_run();
  end
endmodule